// File: doc/BRIEF.md
# Programmable Countdown Timer with Auto-Reload

This block is an 8-bit down-counter that advances on one of four slow tick strobes. A separate prescaler supplies the strobes; the timer only picks one of them. Software writes a start value, which also becomes the reload value, and then sets the run bit. Each selected tick while running lowers the count by one. When the count reaches zero the timer raises its zero flag. Then, depending on the reload mode, it either reloads the stored value and keeps counting or stops at zero.

The flag drives an active-low, level interrupt request whenever the interrupt enable is set. The flag stays set until software writes a 0 to it. One shared output pin carries either that interrupt request or a free-running clock supplied from outside. After reset the pin carries the clock.

The write side is a set of single-cycle write strobes with data, with no bus protocol. The count and the flag can be observed directly.

Top module: `countdown_timer`

## Requirements
- R1: After reset the count is 0, the flag is 0, the timer is stopped, the rate code is 1, reload mode is off, the interrupt enable is off and the pin carries `clkSrc`.
- R2: Rate code k (cfgData[1:0]) selects strobe bit `rateStrobe[k]`: code 0 is 4096 Hz, code 1 is 32 Hz, code 2 is 1 Hz and code 3 is once per minute. Strobes on the other bits leave the count unchanged.
- R3: A write on `reloadWe` loads both the count and the stored reload value. While running (`runData`=1 latched by `runWe`), each selected tick lowers the count by one. While stopped, ticks leave the count unchanged.
- R4: A selected tick at count 1 moves the count to zero and sets the flag. A selected tick at a freshly loaded count of 0 also sets the flag.
- R5: With reload mode off (cfgData[2]=0), the count stays at zero after the zero event. Further ticks neither change it nor set the flag again until a new start value is written.
- R6: With reload mode on (cfgData[2]=1), the tick that reaches zero loads the stored reload value in the same cycle, so a start value N gives one zero event every N ticks.
- R7: Writing 0 on `flagData` with `flagWe` clears the flag and writing 1 has no effect. A zero event in the same cycle wins over the clear.
- R8: The interrupt request is low exactly while the flag is set and the interrupt enable (cfgData[3]) is 1. It is a level that holds until the flag clears.
- R9: With clock select cfgData[4]=0 the pin carries the interrupt request. With cfgData[4]=1 it carries `clkSrc`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rateStrobe | input | 4 | Single-cycle tick strobes from the prescaler, one bit per rate code |
| clkSrc | input | 1 | Free-running clock routed to the pin when clock select is set |
| cfgWe | input | 1 | Write strobe for the configuration fields |
| cfgData | input | 5 | [1:0] rate code, [2] reload mode, [3] interrupt enable, [4] clock select |
| runWe | input | 1 | Write strobe for the run bit |
| runData | input | 1 | Run bit value |
| reloadWe | input | 1 | Write strobe for the start/reload value |
| reloadData | input | 8 | Start/reload value |
| flagWe | input | 1 | Write strobe for the zero flag |
| flagData | input | 1 | Flag write value (0 clears, 1 ignored) |
| countOut | output | 8 | Current count |
| flagOut | output | 1 | Zero flag |
| pinOut | output | 1 | Shared pin: active-low interrupt request or clock |

## Verification
Some behaviours are checked by assertions on every cycle, against shadow copies of the written configuration:
- A stopped timer never moves its count.
- The count only steps down by one unless it is rewritten.
- The flag rises only from a count of one or zero.
- A one-shot timer at zero stays there.
- The pin shows the clock, or a low request, whenever the shadowed select and enable call for it.

Other behaviours only the scenarios can show, because each needs a chosen sequence of strobes and writes: the exact reset values, which strobe bit each rate code picks, the reload period, the priority of a zero event over a clear, and the masking of the request.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;      // take a new start value
    logic step;      // one selected tick while running
    logic reloadOn;  // behaviour at zero for this step
  } tmr_strobe_t;

  // Status from datapath to control
  typedef struct packed {
    logic atEdge;    // next step lands on zero
    logic halted;    // one-shot finished, waiting for a new start value
  } tmr_status_t;

endpackage

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmr_strobe_t      stb,
  input  logic [CNT_W-1:0] loadValue,
  output tmr_status_t      stat,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] ZERO = '0;

  logic [CNT_W-1:0] reloadReg;
  logic             haltedQ;
  logic [CNT_W-1:0] countNext;
  logic [CNT_W-1:0] reloadNext;
  logic             haltedNext;
  logic             atEdge;

  assign atEdge = (count <= ONE);

  always_comb begin
    countNext  = count;
    reloadNext = reloadReg;
    haltedNext = haltedQ;
    if (stb.load) begin
      countNext  = loadValue;
      reloadNext = loadValue;
      haltedNext = 1'b0;
    end else if (stb.step) begin
      if (atEdge) begin
        if (stb.reloadOn) begin
          countNext = reloadReg;
        end else begin
          countNext  = ZERO;
          haltedNext = 1'b1;
        end
      end else begin
        countNext = count - ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count     <= ZERO;
      reloadReg <= ZERO;
      haltedQ   <= 1'b0;
    end else begin
      count     <= countNext;
      reloadReg <= reloadNext;
      haltedQ   <= haltedNext;
    end
  end

  assign stat.atEdge = atEdge;
  assign stat.halted = haltedQ;

endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int NUM_RATES  = 4,
  parameter int RESET_RATE = 1,
  parameter int RATE_W     = 2,
  parameter int CFG_W      = 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_RATES-1:0] rateStrobe,
  input  logic                 clkSrc,
  input  logic                 cfgWe,
  input  logic [CFG_W-1:0]     cfgData,
  input  logic                 runWe,
  input  logic                 runData,
  input  logic                 reloadWe,
  input  logic                 flagWe,
  input  logic                 flagData,
  input  tmr_status_t          stat,
  output tmr_strobe_t          stb,
  output logic                 flagOut,
  output logic                 pinOut
);

  localparam int BIT_RELOAD = RATE_W;
  localparam int BIT_IRQEN  = RATE_W + 1;
  localparam int BIT_CLKSEL = RATE_W + 2;

  logic [RATE_W-1:0]    rateSel;
  logic                 reloadEn;
  logic                 irqEn;
  logic                 clkSel;
  logic                 timerEn;
  logic                 flagQ;
  logic [NUM_RATES-1:0] rateHit;
  logic                 selTick;
  logic                 step;
  logic                 fire;
  logic                 irqN;

  // Configuration and run registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rateSel  <= RATE_W'(RESET_RATE);
      reloadEn <= 1'b0;
      irqEn    <= 1'b0;
      clkSel   <= 1'b1;
    end else if (cfgWe) begin
      rateSel  <= cfgData[RATE_W-1:0];
      reloadEn <= cfgData[BIT_RELOAD];
      irqEn    <= cfgData[BIT_IRQEN];
      clkSel   <= cfgData[BIT_CLKSEL];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timerEn <= 1'b0;
    end else if (runWe) begin
      timerEn <= runData;
    end
  end

  // Rate selection: decode the code against every strobe bit
  for (genvar i = 0; i < NUM_RATES; i++) begin : g_rate
    assign rateHit[i] = rateStrobe[i] && (rateSel == RATE_W'(i));
  end
  assign selTick = |rateHit;

  // A start-value write takes the cycle; otherwise a selected tick steps
  assign step = selTick && timerEn && !stat.halted && !reloadWe;
  assign fire = step && stat.atEdge;

  assign stb.load     = reloadWe;
  assign stb.step     = step;
  assign stb.reloadOn = reloadEn;

  // Zero flag: a zero event wins over a clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ <= 1'b0;
    end else if (fire) begin
      flagQ <= 1'b1;
    end else if (flagWe && !flagData) begin
      flagQ <= 1'b0;
    end
  end

  assign flagOut = flagQ;
  assign irqN    = !(flagQ && irqEn);
  assign pinOut  = clkSel ? clkSrc : irqN;

endmodule

// File: rtl/countdown_timer.sv
module countdown_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int NUM_RATES  = 4,
  parameter int RESET_RATE = 1,
  localparam int RATE_W    = (NUM_RATES > 1) ? $clog2(NUM_RATES) : 1,
  localparam int CFG_W     = RATE_W + 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_RATES-1:0] rateStrobe,
  input  logic                 clkSrc,
  input  logic                 cfgWe,
  input  logic [CFG_W-1:0]     cfgData,
  input  logic                 runWe,
  input  logic                 runData,
  input  logic                 reloadWe,
  input  logic [CNT_W-1:0]     reloadData,
  input  logic                 flagWe,
  input  logic                 flagData,
  output logic [CNT_W-1:0]     countOut,
  output logic                 flagOut,
  output logic                 pinOut
);

  tmr_strobe_t stb;
  tmr_status_t stat;

  tmr_ctrl #(
    .NUM_RATES (NUM_RATES),
    .RESET_RATE(RESET_RATE),
    .RATE_W    (RATE_W),
    .CFG_W     (CFG_W)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .rateStrobe(rateStrobe),
    .clkSrc    (clkSrc),
    .cfgWe     (cfgWe),
    .cfgData   (cfgData),
    .runWe     (runWe),
    .runData   (runData),
    .reloadWe  (reloadWe),
    .flagWe    (flagWe),
    .flagData  (flagData),
    .stat      (stat),
    .stb       (stb),
    .flagOut   (flagOut),
    .pinOut    (pinOut)
  );

  tmr_datapath #(
    .CNT_W(CNT_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .loadValue(reloadData),
    .stat     (stat),
    .count    (countOut)
  );

endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int CNT_W  = 8,
  parameter int RATE_W = 2,
  parameter int CFG_W  = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic             clkSrc,
  input logic             cfgWe,
  input logic [CFG_W-1:0] cfgData,
  input logic             runWe,
  input logic             runData,
  input logic             reloadWe,
  input logic [CNT_W-1:0] countOut,
  input logic             flagOut,
  input logic             pinOut
);

  // Shadow copies of the written configuration
  logic runS, reloadS, irqS, clkSelS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runS    <= 1'b0;
      reloadS <= 1'b0;
      irqS    <= 1'b0;
      clkSelS <= 1'b1;
    end else begin
      if (runWe) runS <= runData;
      if (cfgWe) begin
        reloadS <= cfgData[RATE_W];
        irqS    <= cfgData[RATE_W+1];
        clkSelS <= cfgData[RATE_W+2];
      end
    end
  end

  AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!runS && !reloadWe) |=> $stable(countOut)); // R3

  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (countOut > CNT_W'(1) && !reloadWe) |=>
      (countOut == $past(countOut) || countOut == $past(countOut) - CNT_W'(1))); // R3

  AST_FLAG_FROM_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagOut) |-> ($past(countOut) <= CNT_W'(1))); // R4

  AST_ONESHOT_PARKED: assert property (@(posedge clk) disable iff (!rstN)
    (countOut == '0 && !reloadWe && !reloadS) |=> (countOut == '0)); // R5

  AST_IRQ_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (!clkSelS && irqS && flagOut) |-> !pinOut); // R8

  AST_PIN_CLOCK: assert property (@(posedge clk) disable iff (!rstN)
    clkSelS |-> (pinOut == clkSrc)); // R9

endmodule

bind countdown_timer tmr_checker #(
  .CNT_W (CNT_W),
  .RATE_W(RATE_W),
  .CFG_W (CFG_W)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .clkSrc  (clkSrc),
  .cfgWe   (cfgWe),
  .cfgData (cfgData),
  .runWe   (runWe),
  .runData (runData),
  .reloadWe(reloadWe),
  .countOut(countOut),
  .flagOut (flagOut),
  .pinOut  (pinOut)
);

// File: tb/tb_countdown_timer.sv
module tb_countdown_timer;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] rateStrobe = '0;
  logic       clkSrc = 1'b1;
  logic       cfgWe = 1'b0;
  logic [4:0] cfgData = '0;
  logic       runWe = 1'b0;
  logic       runData = 1'b0;
  logic       reloadWe = 1'b0;
  logic [7:0] reloadData = '0;
  logic       flagWe = 1'b0;
  logic       flagData = 1'b0;
  logic [7:0] countOut;
  logic       flagOut;
  logic       pinOut;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [7:0] cnt;
    logic       flg;
    logic       pin;
    string      tag;
  } item_t;

  item_t expQ[$];

  always #2 clk = ~clk;

  countdown_timer dut (
    .clk(clk), .rstN(rstN), .rateStrobe(rateStrobe), .clkSrc(clkSrc),
    .cfgWe(cfgWe), .cfgData(cfgData), .runWe(runWe), .runData(runData),
    .reloadWe(reloadWe), .reloadData(reloadData), .flagWe(flagWe),
    .flagData(flagData), .countOut(countOut), .flagOut(flagOut), .pinOut(pinOut)
  );

  // Monitor: pops expected items and compares away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      while (expQ.size() > 0) begin
        item_t it;
        it = expQ.pop_front();
        checks++;
        if (countOut !== it.cnt || flagOut !== it.flg || pinOut !== it.pin) begin
          errors++;
          $display("FAIL %s: count=%0d exp %0d, flag=%0b exp %0b, pin=%0b exp %0b",
                   it.tag, countOut, it.cnt, flagOut, it.flg, pinOut, it.pin);
        end
      end
    end
  end

  task automatic expect_state(input logic [7:0] c, input logic f, input logic p, input string tag);
    item_t it;
    it.cnt = c; it.flg = f; it.pin = p; it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic finish_edge();
    @(posedge clk);
    #1;
    rateStrobe = '0; cfgWe = 1'b0; runWe = 1'b0; reloadWe = 1'b0; flagWe = 1'b0;
  endtask

  task automatic tick(input logic [3:0] m);
    @(negedge clk); rateStrobe = m; finish_edge();
  endtask

  task automatic tick_clear(input logic [3:0] m);
    @(negedge clk); rateStrobe = m; flagWe = 1'b1; flagData = 1'b0; finish_edge();
  endtask

  task automatic write_cfg(input logic [4:0] v);
    @(negedge clk); cfgWe = 1'b1; cfgData = v; finish_edge();
  endtask

  task automatic write_run(input logic v);
    @(negedge clk); runWe = 1'b1; runData = v; finish_edge();
  endtask

  task automatic write_reload(input logic [7:0] v);
    @(negedge clk); reloadWe = 1'b1; reloadData = v; finish_edge();
  endtask

  task automatic write_flag(input logic v);
    @(negedge clk); flagWe = 1'b1; flagData = v; finish_edge();
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // Driver
  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    expect_state(8'd0, 1'b0, 1'b1, "R1 reset state, pin carries clock (high)");
    @(posedge clk); #1 clkSrc = 1'b0;
    expect_state(8'd0, 1'b0, 1'b0, "R1 R9 pin follows clock low");

    // Start value while stopped
    write_reload(8'd3);        expect_state(8'd3, 1'b0, 1'b0, "R3 load start value");
    tick(4'b0010);             expect_state(8'd3, 1'b0, 1'b0, "R3 stopped ignores tick");

    // Run at default rate code 1
    write_run(1'b1);           expect_state(8'd3, 1'b0, 1'b0, "R3 run write");
    tick(4'b0001);             expect_state(8'd3, 1'b0, 1'b0, "R1 R2 code1 ignores strobe bit0");
    tick(4'b0010);             expect_state(8'd2, 1'b0, 1'b0, "R1 R3 default rate decrements");
    tick(4'b0010);             expect_state(8'd1, 1'b0, 1'b0, "R3 decrement");
    tick(4'b0010);             expect_state(8'd0, 1'b1, 1'b0, "R4 reach zero sets flag");

    // One-shot parked at zero
    tick(4'b0010);             expect_state(8'd0, 1'b1, 1'b0, "R5 parked at zero");
    write_flag(1'b1);          expect_state(8'd0, 1'b1, 1'b0, "R7 writing 1 ignored");
    write_flag(1'b0);          expect_state(8'd0, 1'b0, 1'b0, "R7 writing 0 clears");
    tick(4'b0010);             expect_state(8'd0, 1'b0, 1'b0, "R5 no new zero event");

    // Rate 2, reload on, interrupt enabled, pin carries request
    write_cfg(5'h0E);          expect_state(8'd0, 1'b0, 1'b1, "R9 pin carries idle request");
    write_reload(8'd2);        expect_state(8'd2, 1'b0, 1'b1, "R3 new start value");
    tick(4'b0010);             expect_state(8'd2, 1'b0, 1'b1, "R2 code2 ignores 32Hz strobe");
    tick(4'b0100);             expect_state(8'd1, 1'b0, 1'b1, "R2 code2 uses 1Hz strobe");
    tick(4'b0100);             expect_state(8'd2, 1'b1, 1'b0, "R6 R8 reload at zero, request low");
    tick(4'b0100);             expect_state(8'd1, 1'b1, 1'b0, "R8 request holds as level");
    tick_clear(4'b0100);       expect_state(8'd2, 1'b1, 1'b0, "R6 R7 zero event beats clear");
    write_cfg(5'h06);          expect_state(8'd2, 1'b1, 1'b1, "R8 request masked by enable");
    write_cfg(5'h0E);          expect_state(8'd2, 1'b1, 1'b0, "R8 request unmasked");
    write_flag(1'b0);          expect_state(8'd2, 1'b0, 1'b1, "R8 request released");

    // Clock routing
    write_cfg(5'h1E);          expect_state(8'd2, 1'b0, 1'b0, "R9 pin carries clock low");
    @(posedge clk); #1 clkSrc = 1'b1;
    expect_state(8'd2, 1'b0, 1'b1, "R9 pin carries clock high");
    @(posedge clk); #1 clkSrc = 1'b0;

    // Rate codes 3 and 0
    write_cfg(5'h0F);          expect_state(8'd2, 1'b0, 1'b1, "R9 back to request");
    tick(4'b0100);             expect_state(8'd2, 1'b0, 1'b1, "R2 code3 ignores 1Hz strobe");
    tick(4'b1000);             expect_state(8'd1, 1'b0, 1'b1, "R2 code3 uses minute strobe");
    write_cfg(5'h0C);          expect_state(8'd1, 1'b0, 1'b1, "R2 switch to code0");
    tick(4'b0001);             expect_state(8'd2, 1'b1, 1'b0, "R2 R6 code0 zero and reload");
    write_flag(1'b0);          expect_state(8'd2, 1'b0, 1'b1, "R7 clear");

    // Start value zero, one-shot
    write_cfg(5'h08);          expect_state(8'd2, 1'b0, 1'b1, "R5 reload off");
    write_reload(8'd0);        expect_state(8'd0, 1'b0, 1'b1, "R3 start value zero");
    tick(4'b0001);             expect_state(8'd0, 1'b1, 1'b0, "R4 zero start flags next tick");
    write_flag(1'b0);          expect_state(8'd0, 1'b0, 1'b1, "R7 clear");
    tick(4'b0001);             expect_state(8'd0, 1'b0, 1'b1, "R5 no repeat after zero start");

    // Stop
    write_run(1'b0);           expect_state(8'd0, 1'b0, 1'b1, "R3 stop");
    write_reload(8'd4);        expect_state(8'd4, 1'b0, 1'b1, "R3 load while stopped");
    tick(4'b0001);             expect_state(8'd4, 1'b0, 1'b1, "R3 stopped holds count");

    repeat (3) @(posedge clk);
    wait (expQ.size() == 0);
    @(negedge clk);
    report();
  end

  // Watchdog
  initial begin
    #20000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, count=%0d exp done", countOut);
      report();
    end
  end

endmodule